// File: doc/BRIEF.md
# Multicycle Instruction Control Sequencer

This block is the control unit of a small multicycle processor with a 32-bit datapath. It moves through up to five states: fetch, decode, execute, memory and write-back. In each state it drives the datapath enables and selects that the current 6-bit opcode needs. Each instruction class takes its own route through those states. Register and immediate ALU operations skip the memory state. Branches and jumps finish in execute. Stores finish in memory. Loads with a pointer post-increment spend two cycles in write-back. Calls, returns, pushes and pops hold their stack request in the memory state until the memory side signals completion.

The datapath owns the instruction register, the register file, the PC, the stack pointer and both memories. It presents the opcode field of the instruction register once decode has begun. It also supplies a branch-taken flag from its comparator, a memory-done handshake for stack transfers, and two flags that say whether the destination or source register field selects the zero register. Control outputs are combinational from the state register and these inputs.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: An asynchronous active-low reset puts the sequencer in the fetch state. State codes on `state_o` are fetch=0, decode=1, execute=2, memory=3, write-back=4.
- R2: Fetch asserts only `ir_ld_o` and `pc_we_o`, with `pc_src_o`=0 (increment), and moves to decode. Decode asserts nothing and moves to execute for every defined opcode. Every output not named for a state is 0 in that state.
- R3: AND=000000, ADD=000001, SUB=000010, ANDI=000011 and ADDI=000100 run fetch, decode, execute, write-back. Execute drives `alu_op_o` (0 AND, 1 ADD, 2 SUB) with `alu_bsrc_o`=1 for the two immediate forms. Write-back sets `rf_we_o` with `rf_wsrc_o`=0 (ALU) and `rf_wdst_o`=0 (Rd).
- R4: LW=000101 and SW=000111 compute the address in execute (`alu_op_o`=1, `alu_bsrc_o`=1). In the memory state LW asserts `mem_rd_o` and then writes back with `rf_wsrc_o`=1 (memory). SW asserts `mem_wr_o` and returns to fetch.
- R5: The post-increment load 000110 follows the LW path but has two write-back cycles. The first writes Rd from memory. The second writes Rs1 (`rf_wdst_o`=1) from the incremented source (`rf_wsrc_o`=2).
- R6: BGT=001000, BLT=001001, BEQ=001010 and BNE=001011 end in execute with `alu_op_o`=2, `alu_bsrc_o`=0 and `pc_src_o`=1. There `pc_we_o` follows `branch_taken_i`.
- R7: JMP=001100 ends in execute with `pc_we_o`=1 and `pc_src_o`=2.
- R8: CALL=001101 and PUSH=001111 assert `stk_push_o`; RET=001110 and POP=010000 assert `stk_pop_o`. Each holds its request in the memory state until `mem_done_i`. In that final cycle CALL sets `pc_we_o` with `pc_src_o`=2, and RET sets it with `pc_src_o`=3. POP then writes Rd from memory in write-back.
- R9: A write-back that targets Rd while `rd_zero_i` is high, or targets Rs1 while `rs_zero_i` is high, keeps `rf_we_o` low. The select outputs are unchanged.
- R10: Any opcode from 010001 to 111111 goes from decode straight back to fetch with no enable raised. Only the fetch increment advances the PC.
- R11: `branch_taken_i` is ignored outside a branch in execute. `mem_done_i` is ignored outside a stack operation in the memory state.
- R12: At most one of `mem_rd_o`, `mem_wr_o`, `stk_push_o`, `stk_pop_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode_i | input | 6 | Opcode field of the instruction register |
| branch_taken_i | input | 1 | Branch condition result from the datapath |
| mem_done_i | input | 1 | Stack transfer complete |
| rd_zero_i | input | 1 | Rd field selects the zero register |
| rs_zero_i | input | 1 | Rs1 field selects the zero register |
| state_o | output | 3 | Current state code |
| pc_we_o | output | 1 | PC write enable |
| pc_src_o | output | 2 | PC source: 0 increment, 1 branch, 2 jump target, 3 stack |
| ir_ld_o | output | 1 | Instruction register load |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdst_o | output | 1 | Write destination: 0 Rd, 1 Rs1 |
| rf_wsrc_o | output | 2 | Write source: 0 ALU, 1 memory, 2 Rs1 plus one |
| alu_op_o | output | 2 | ALU function: 0 AND, 1 ADD, 2 SUB |
| alu_bsrc_o | output | 1 | ALU B operand: 0 register, 1 immediate |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| stk_push_o | output | 1 | Stack push request |
| stk_pop_o | output | 1 | Stack pop request |

## Verification
Every one of the 17 defined opcodes is run, along with three undefined ones, and every control output is compared in every cycle. This separates the class routes from one another and shows whether an opcode was decoded into the wrong class. Branches are run with the taken flag both high and low to confirm that the PC enable follows the comparator. Stack operations are run with completion delays of zero, one and three cycles to show that the request is held and the PC or write-back fires only on the completion cycle. Both flags are driven high while they should have no effect, and the zero-register flags are raised on loads and ALU writes. Together these show that spurious inputs change nothing and that writes to register zero are suppressed, including the second write-back of the post-increment load.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OP_W   = 6;
  localparam int ST_W   = 3;
  localparam int ALU_W  = 2;
  localparam int PCS_W  = 2;
  localparam int WS_W   = 2;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEM    = 3'd3,
    ST_WB     = 3'd4
  } state_e;

  typedef enum logic [3:0] {
    CL_ALU_R, CL_ALU_I, CL_LOAD, CL_LOAD_PI, CL_STORE, CL_BRANCH,
    CL_JUMP, CL_CALL, CL_RET, CL_PUSH, CL_POP, CL_ILLEGAL
  } class_e;

  localparam logic [ALU_W-1:0] ALU_AND = 2'd0;
  localparam logic [ALU_W-1:0] ALU_ADD = 2'd1;
  localparam logic [ALU_W-1:0] ALU_SUB = 2'd2;

  localparam logic [PCS_W-1:0] PCS_INC = 2'd0;
  localparam logic [PCS_W-1:0] PCS_BR  = 2'd1;
  localparam logic [PCS_W-1:0] PCS_JMP = 2'd2;
  localparam logic [PCS_W-1:0] PCS_STK = 2'd3;

  localparam logic [WS_W-1:0] WS_ALU = 2'd0;
  localparam logic [WS_W-1:0] WS_MEM = 2'd1;
  localparam logic [WS_W-1:0] WS_INC = 2'd2;

  localparam logic [OP_W-1:0] OPC_AND   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_ADD   = 6'b000001;
  localparam logic [OP_W-1:0] OPC_SUB   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_ANDI  = 6'b000011;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'b000100;
  localparam logic [OP_W-1:0] OPC_LW    = 6'b000101;
  localparam logic [OP_W-1:0] OPC_LWPI  = 6'b000110;
  localparam logic [OP_W-1:0] OPC_SW    = 6'b000111;
  localparam logic [OP_W-1:0] OPC_BGT   = 6'b001000;
  localparam logic [OP_W-1:0] OPC_BLT   = 6'b001001;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b001010;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'b001011;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b001100;
  localparam logic [OP_W-1:0] OPC_CALL  = 6'b001101;
  localparam logic [OP_W-1:0] OPC_RET   = 6'b001110;
  localparam logic [OP_W-1:0] OPC_PUSH  = 6'b001111;
  localparam logic [OP_W-1:0] OPC_POP   = 6'b010000;

  function automatic class_e classify(input logic [OP_W-1:0] op);
    case (op)
      OPC_AND, OPC_ADD, OPC_SUB:            classify = CL_ALU_R;
      OPC_ANDI, OPC_ADDI:                   classify = CL_ALU_I;
      OPC_LW:                               classify = CL_LOAD;
      OPC_LWPI:                             classify = CL_LOAD_PI;
      OPC_SW:                               classify = CL_STORE;
      OPC_BGT, OPC_BLT, OPC_BEQ, OPC_BNE:   classify = CL_BRANCH;
      OPC_JMP:                              classify = CL_JUMP;
      OPC_CALL:                             classify = CL_CALL;
      OPC_RET:                              classify = CL_RET;
      OPC_PUSH:                             classify = CL_PUSH;
      OPC_POP:                              classify = CL_POP;
      default:                              classify = CL_ILLEGAL;
    endcase
  endfunction

  function automatic logic [ALU_W-1:0] alu_fn(input logic [OP_W-1:0] op);
    case (op)
      OPC_SUB, OPC_BGT, OPC_BLT, OPC_BEQ, OPC_BNE: alu_fn = ALU_SUB;
      OPC_ADD, OPC_ADDI, OPC_LW, OPC_LWPI, OPC_SW: alu_fn = ALU_ADD;
      default:                                     alu_fn = ALU_AND;
    endcase
  endfunction

  function automatic logic uses_imm(input logic [OP_W-1:0] op);
    case (op)
      OPC_ANDI, OPC_ADDI, OPC_LW, OPC_LWPI, OPC_SW: uses_imm = 1'b1;
      default:                                      uses_imm = 1'b0;
    endcase
  endfunction

  function automatic logic is_stack(input class_e c);
    is_stack = (c == CL_CALL) || (c == CL_RET) || (c == CL_PUSH) || (c == CL_POP);
  endfunction

  function automatic logic is_load(input class_e c);
    is_load = (c == CL_LOAD) || (c == CL_LOAD_PI);
  endfunction

  function automatic logic uses_alu(input class_e c);
    uses_alu = (c == CL_ALU_R) || (c == CL_ALU_I) || (c == CL_LOAD) ||
               (c == CL_LOAD_PI) || (c == CL_STORE) || (c == CL_BRANCH);
  endfunction

endpackage

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  logic [OP_W-1:0]  opcode_i,
  output class_e           cls_o,
  output logic [ALU_W-1:0] alu_fn_o,
  output logic             bsrc_imm_o
);

  always_comb begin
    cls_o      = classify(opcode_i);
    alu_fn_o   = alu_fn(opcode_i);
    bsrc_imm_o = uses_imm(opcode_i);
  end

endmodule

// File: rtl/mc_ctrl_seq.sv
module mc_ctrl_seq
  import mc_ctrl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  class_e cls_i,
  input  logic   mem_done_i,
  output state_e state_o,
  output logic   wb_second_o
);

  state_e state_q, state_d;
  logic   wb2_q, wb2_d;

  // Named events for the checks below
  logic stack_wait;
  logic illegal_exit;
  logic wb_last;

  function automatic state_e next_state(input state_e s, input class_e c,
                                        input logic done, input logic second);
    next_state = ST_FETCH;
    case (s)
      ST_FETCH:  next_state = ST_DECODE;
      ST_DECODE: next_state = (c == CL_ILLEGAL) ? ST_FETCH : ST_EXEC;
      ST_EXEC: begin
        if (c == CL_ALU_R || c == CL_ALU_I)          next_state = ST_WB;
        else if (c == CL_BRANCH || c == CL_JUMP)     next_state = ST_FETCH;
        else                                         next_state = ST_MEM;
      end
      ST_MEM: begin
        if (is_stack(c)) begin
          if (!done)             next_state = ST_MEM;
          else if (c == CL_POP)  next_state = ST_WB;
          else                   next_state = ST_FETCH;
        end else if (is_load(c)) next_state = ST_WB;
        else                     next_state = ST_FETCH;
      end
      ST_WB: next_state = (c == CL_LOAD_PI && !second) ? ST_WB : ST_FETCH;
      default: next_state = ST_FETCH;
    endcase
  endfunction

  always_comb begin
    state_d = next_state(state_q, cls_i, mem_done_i, wb2_q);
    wb2_d   = (state_q == ST_WB) && (state_d == ST_WB);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      wb2_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wb2_q   <= wb2_d;
    end
  end

  assign state_o      = state_q;
  assign wb_second_o  = wb2_q;
  assign stack_wait   = (state_q == ST_MEM) && is_stack(cls_i) && !mem_done_i;
  assign illegal_exit = (state_q == ST_DECODE) && (cls_i == CL_ILLEGAL);
  assign wb_last      = (state_q == ST_WB) && wb2_q;

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

  assert_stack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stack_wait |=> (state_q == ST_MEM));

  assert_illegal_refetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_exit |=> (state_q == ST_FETCH));

  assert_second_wb_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wb_last |=> (state_q == ST_FETCH));

  assert_second_wb_only_after_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb2_q) |-> ($past(state_q) == ST_WB));

endmodule

// File: rtl/mc_ctrl_outgen.sv
module mc_ctrl_outgen
  import mc_ctrl_pkg::*;
(
  input  state_e           state_i,
  input  logic             wb_second_i,
  input  class_e           cls_i,
  input  logic [ALU_W-1:0] alu_fn_i,
  input  logic             bsrc_imm_i,
  input  logic             branch_taken_i,
  input  logic             mem_done_i,
  input  logic             rd_zero_i,
  input  logic             rs_zero_i,
  output logic             pc_we_o,
  output logic [PCS_W-1:0] pc_src_o,
  output logic             ir_ld_o,
  output logic             rf_we_o,
  output logic             rf_wdst_o,
  output logic [WS_W-1:0]  rf_wsrc_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             alu_bsrc_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             stk_push_o,
  output logic             stk_pop_o
);

  always_comb begin
    pc_we_o    = 1'b0;
    pc_src_o   = PCS_INC;
    ir_ld_o    = 1'b0;
    rf_we_o    = 1'b0;
    rf_wdst_o  = 1'b0;
    rf_wsrc_o  = WS_ALU;
    alu_op_o   = ALU_AND;
    alu_bsrc_o = 1'b0;
    mem_rd_o   = 1'b0;
    mem_wr_o   = 1'b0;
    stk_push_o = 1'b0;
    stk_pop_o  = 1'b0;
    case (state_i)
      ST_FETCH: begin
        ir_ld_o = 1'b1;
        pc_we_o = 1'b1;
      end
      ST_EXEC: begin
        if (uses_alu(cls_i)) begin
          alu_op_o   = alu_fn_i;
          alu_bsrc_o = bsrc_imm_i;
        end
        if (cls_i == CL_BRANCH) begin
          pc_src_o = PCS_BR;
          pc_we_o  = branch_taken_i;
        end else if (cls_i == CL_JUMP) begin
          pc_src_o = PCS_JMP;
          pc_we_o  = 1'b1;
        end
      end
      ST_MEM: begin
        mem_rd_o   = is_load(cls_i);
        mem_wr_o   = (cls_i == CL_STORE);
        stk_push_o = (cls_i == CL_CALL) || (cls_i == CL_PUSH);
        stk_pop_o  = (cls_i == CL_RET) || (cls_i == CL_POP);
        if (cls_i == CL_CALL) begin
          pc_src_o = PCS_JMP;
          pc_we_o  = mem_done_i;
        end else if (cls_i == CL_RET) begin
          pc_src_o = PCS_STK;
          pc_we_o  = mem_done_i;
        end
      end
      ST_WB: begin
        if (wb_second_i) begin
          rf_wdst_o = 1'b1;
          rf_wsrc_o = WS_INC;
          rf_we_o   = !rs_zero_i;
        end else begin
          rf_wsrc_o = (is_load(cls_i) || cls_i == CL_POP) ? WS_MEM : WS_ALU;
          rf_we_o   = !rd_zero_i;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic             branch_taken_i,
  input  logic             mem_done_i,
  input  logic             rd_zero_i,
  input  logic             rs_zero_i,
  output logic [ST_W-1:0]  state_o,
  output logic             pc_we_o,
  output logic [PCS_W-1:0] pc_src_o,
  output logic             ir_ld_o,
  output logic             rf_we_o,
  output logic             rf_wdst_o,
  output logic [WS_W-1:0]  rf_wsrc_o,
  output logic [ALU_W-1:0] alu_op_o,
  output logic             alu_bsrc_o,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic             stk_push_o,
  output logic             stk_pop_o
);

  class_e           cls;
  logic [ALU_W-1:0] alu_fn_w;
  logic             bsrc_imm;
  state_e           state;
  logic             wb_second;

  mc_ctrl_decode u_decode (
    .opcode_i   (opcode_i),
    .cls_o      (cls),
    .alu_fn_o   (alu_fn_w),
    .bsrc_imm_o (bsrc_imm)
  );

  mc_ctrl_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cls_i       (cls),
    .mem_done_i  (mem_done_i),
    .state_o     (state),
    .wb_second_o (wb_second)
  );

  mc_ctrl_outgen u_outgen (
    .state_i        (state),
    .wb_second_i    (wb_second),
    .cls_i          (cls),
    .alu_fn_i       (alu_fn_w),
    .bsrc_imm_i     (bsrc_imm),
    .branch_taken_i (branch_taken_i),
    .mem_done_i     (mem_done_i),
    .rd_zero_i      (rd_zero_i),
    .rs_zero_i      (rs_zero_i),
    .pc_we_o        (pc_we_o),
    .pc_src_o       (pc_src_o),
    .ir_ld_o        (ir_ld_o),
    .rf_we_o        (rf_we_o),
    .rf_wdst_o      (rf_wdst_o),
    .rf_wsrc_o      (rf_wsrc_o),
    .alu_op_o       (alu_op_o),
    .alu_bsrc_o     (alu_bsrc_o),
    .mem_rd_o       (mem_rd_o),
    .mem_wr_o       (mem_wr_o),
    .stk_push_o     (stk_push_o),
    .stk_pop_o      (stk_pop_o)
  );

  assign state_o = state;

  assert_one_mem_request_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_o, mem_wr_o, stk_push_o, stk_pop_o}));

  assert_rf_write_in_wb_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (state == ST_WB));

  assert_no_r0_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we_o && !rf_wdst_o) |-> !rd_zero_i);

  assert_decode_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE) |-> !(pc_we_o || ir_ld_o || rf_we_o || mem_rd_o ||
                               mem_wr_o || stk_push_o || stk_pop_o));

  assert_ir_then_decode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld_o |=> (state == ST_DECODE));

  assert_stack_pc_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((stk_push_o || stk_pop_o) && pc_we_o) |-> mem_done_i);

endmodule

// File: tb/mc_ctrl_fsm_tb_top.sv
module mc_ctrl_fsm_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode_i = '0;
  logic       branch_taken_i = 1'b0;
  logic       mem_done_i = 1'b0;
  logic       rd_zero_i = 1'b0;
  logic       rs_zero_i = 1'b0;
  logic [2:0] state_o;
  logic       pc_we_o, ir_ld_o, rf_we_o, rf_wdst_o, alu_bsrc_o;
  logic [1:0] pc_src_o, rf_wsrc_o, alu_op_o;
  logic       mem_rd_o, mem_wr_o, stk_push_o, stk_pop_o;

  always #4 clk = ~clk;

  mc_ctrl_fsm dut_i (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i),
    .branch_taken_i(branch_taken_i), .mem_done_i(mem_done_i),
    .rd_zero_i(rd_zero_i), .rs_zero_i(rs_zero_i),
    .state_o(state_o), .pc_we_o(pc_we_o), .pc_src_o(pc_src_o),
    .ir_ld_o(ir_ld_o), .rf_we_o(rf_we_o), .rf_wdst_o(rf_wdst_o),
    .rf_wsrc_o(rf_wsrc_o), .alu_op_o(alu_op_o), .alu_bsrc_o(alu_bsrc_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o),
    .stk_push_o(stk_push_o), .stk_pop_o(stk_pop_o)
  );

  // {state, pc_we, pc_src, ir_ld, rf_we, wdst, wsrc, alu, bsrc, rd, wr, push, pop}
  logic [17:0] obs;
  assign obs = {state_o, pc_we_o, pc_src_o, ir_ld_o, rf_we_o, rf_wdst_o, rf_wsrc_o,
                alu_op_o, alu_bsrc_o, mem_rd_o, mem_wr_o, stk_push_o, stk_pop_o};

  typedef struct {
    logic [17:0] v;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  function automatic logic [17:0] mk(input int st, input bit pcwe, input int pcs,
                                     input bit irld, input bit rfwe, input bit wdst,
                                     input int wsrc, input int alu, input bit bsrc,
                                     input bit mrd, input bit mwr, input bit psh,
                                     input bit pp);
    logic [2:0] s3 = 3'(st);
    logic [1:0] p2 = 2'(pcs);
    logic [1:0] w2 = 2'(wsrc);
    logic [1:0] a2 = 2'(alu);
    return {s3, pcwe, p2, irld, rfwe, wdst, w2, a2, bsrc, mrd, mwr, psh, pp};
  endfunction

  // Monitor: compare one expected item per cycle, away from the clock edge
  always @(negedge clk) begin
    if (rst_n && q.size() != 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (obs !== e.v) begin
        n_fail++;
        $display("FAIL %s: got %b expected %b", e.tag, obs, e.v);
      end
    end
  end

  // Driver: set the cycle's inputs, push its expectation, advance one cycle
  task automatic step(input logic [17:0] v, input string tag, input bit taken, input bit done);
    exp_t e;
    branch_taken_i = taken;
    mem_done_i     = done;
    e.v   = v;
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  task automatic run(input logic [5:0] op, input bit taken, input int dly,
                     input bit rdz, input bit rsz);
    int    o = int'(op);
    string t;
    opcode_i  = op;
    rd_zero_i = rdz;
    rs_zero_i = rsz;
    // R2 fetch and decode; R11 noise on both flags
    step(mk(0,1,0,1,0,0,0,0,0,0,0,0,0), "R2", 1, 1);
    if (o > 16) begin
      step(mk(1,0,0,0,0,0,0,0,0,0,0,0,0), "R10", 1, 1);
      return;
    end
    step(mk(1,0,0,0,0,0,0,0,0,0,0,0,0), "R2", 1, 1);
    if (o <= 4) begin
      int alu = (o == 0 || o == 3) ? 0 : ((o == 2) ? 2 : 1);
      step(mk(2,0,0,0,0,0,0,alu,(o >= 3),0,0,0,0), "R3", 1, 1);
      t = rdz ? "R9" : "R3";
      step(mk(4,0,0,0,!rdz,0,0,0,0,0,0,0,0), t, 1, 1);
    end else if (o == 5 || o == 6) begin
      t = (o == 5) ? "R4" : "R5";
      step(mk(2,0,0,0,0,0,0,1,1,0,0,0,0), t, 1, 1);
      step(mk(3,0,0,0,0,0,0,0,0,1,0,0,0), t, 1, 1);
      step(mk(4,0,0,0,!rdz,0,1,0,0,0,0,0,0), rdz ? "R9" : t, 1, 1);
      if (o == 6)
        step(mk(4,0,0,0,!rsz,1,2,0,0,0,0,0,0), rsz ? "R9" : "R5", 1, 1);
    end else if (o == 7) begin
      step(mk(2,0,0,0,0,0,0,1,1,0,0,0,0), "R4", 1, 1);
      step(mk(3,0,0,0,0,0,0,0,0,0,1,0,0), "R4", 1, 1);
    end else if (o >= 8 && o <= 11) begin
      step(mk(2,taken,1,0,0,0,0,2,0,0,0,0,0), "R6", taken, 1);
    end else if (o == 12) begin
      step(mk(2,1,2,0,0,0,0,0,0,0,0,0,0), "R7", 0, 1);
    end else begin
      bit psh = (o == 13 || o == 15);
      int pcs = (o == 13) ? 2 : ((o == 14) ? 3 : 0);
      bit pcu = (o == 13 || o == 14);
      step(mk(2,0,0,0,0,0,0,0,0,0,0,0,0), "R8", 1, 1);
      for (int k = 0; k <= dly; k++)
        step(mk(3,pcu && (k == dly),pcs,0,0,0,0,0,0,0,0,psh,!psh), "R8", 1, (k == dly));
      if (o == 16)
        step(mk(4,0,0,0,!rdz,0,1,0,0,0,0,0,0), rdz ? "R9" : "R8", 1, 1);
    end
  endtask

  task automatic check_reset_state(input string tag);
    n_chk++;
    if (state_o !== 3'd0) begin
      n_fail++;
      $display("FAIL %s: state %0d expected 0", tag, state_o);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset_state("R1");
    @(posedge clk);
    #1;
    rst_n = 1'b1;

    // Every defined opcode, plain operands
    for (int op = 0; op <= 16; op++) run(6'(op), 1'b1, 0, 1'b0, 1'b0);
    // Branches not taken (R6)
    for (int op = 8; op <= 11; op++) run(6'(op), 1'b0, 0, 1'b0, 1'b0);
    // Stack waits of one and three cycles (R8)
    for (int op = 13; op <= 16; op++) run(6'(op), 1'b0, 1, 1'b0, 1'b0);
    for (int op = 13; op <= 16; op++) run(6'(op), 1'b0, 3, 1'b0, 1'b0);
    // Zero-register targets (R9)
    run(6'd1,  1'b0, 0, 1'b1, 1'b0);
    run(6'd4,  1'b0, 0, 1'b1, 1'b0);
    run(6'd5,  1'b0, 0, 1'b1, 1'b0);
    run(6'd6,  1'b0, 0, 1'b0, 1'b1);
    run(6'd6,  1'b0, 0, 1'b1, 1'b1);
    run(6'd16, 1'b0, 2, 1'b1, 1'b0);
    // Undefined opcodes (R10)
    run(6'b010001, 1'b0, 0, 1'b0, 1'b0);
    run(6'b100000, 1'b0, 0, 1'b0, 1'b0);
    run(6'b111111, 1'b0, 0, 1'b0, 1'b0);
    run(6'd0, 1'b0, 0, 1'b0, 1'b0);

    // Asynchronous reset in the middle of a load (R1)
    opcode_i = 6'd5;
    step(mk(0,1,0,1,0,0,0,0,0,0,0,0,0), "R2", 0, 0);
    step(mk(1,0,0,0,0,0,0,0,0,0,0,0,0), "R2", 0, 0);
    rst_n = 1'b0;
    #1;
    check_reset_state("R1");
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    run(6'd2, 1'b0, 0, 1'b0, 1'b0);

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule